// File: doc/BRIEF.md
# Small CPU Memory Map Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the devices on that bus. For every bus request it decides which device is addressed and raises that device's chip select: one of two 2K×8 RAM banks, a 2K×8 ROM, or a two-register serial peripheral. The low eleven address bits go unchanged to every memory. Write strobes reach only the writable devices.

The memories and the peripheral are synchronous. They return read data one clock after the request. The block therefore registers which device was read and steers that device's output onto the CPU read-data input one cycle later. A read from an address that no device claims returns $00. A stray fetch from empty space then executes the zero opcode, which is a break, and traps the CPU.

The registered source select is a small state machine. Its states are SRC_NONE, SRC_RAM0, SRC_RAM1, SRC_ROM and SRC_IO. On each clock edge it moves to the state of the device hit by the current read. It moves to SRC_NONE when the cycle is idle, is a write, or is a read of unmapped space. Reset puts it in SRC_NONE. In each state the output process passes that device's data, and SRC_NONE drives zero.

Top module: `mem_map_decoder`

## Requirements
- R1: An access to $0000–$07FF raises ram0_cs (on reads and on writes) and no other select.
- R2: An access to $0800–$0FFF raises ram1_cs and no other select.
- R3: A read of $F800–$FFFF raises rom_cs and no other select. rom_cs stays low on writes.
- R4: An access to $1000 or $1001 raises io_cs. io_reg_sel equals address bit 0: 0 selects the data register at $1000 and 1 selects the status register at $1001.
- R5: A read of any other address (for example $1002, $2000, $8000 or $F7FF) raises no select, and cpu_rdata is $00 in the following cycle.
- R6: After a read request in cycle N, cpu_rdata in cycle N+1 equals the data returned by the device selected in cycle N.
- R7: A write to the ROM range or to an unmapped address raises no chip select and leaves mem_we low. mem_we is high only for writes to RAM or to the peripheral.
- R8: At most one of ram0_cs, ram1_cs, rom_cs and io_cs is high in any cycle.
- R9: mem_addr always equals cpu_addr[10:0].
- R10: cpu_rdata is $00 during and after reset until the first read. It is also $00 in the cycle after an idle cycle or after a write.
- R11: Reads of $FFFA–$FFFF return the ROM bytes at offsets $7FA–$7FF. The vector words are little-endian: the low byte is at the even address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Bus request valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| ram0_rdata | input | 8 | Registered read data from RAM bank 0 |
| ram1_rdata | input | 8 | Registered read data from RAM bank 1 |
| rom_rdata | input | 8 | Registered read data from ROM |
| io_rdata | input | 8 | Registered read data from the peripheral |
| mem_addr | output | 11 | Address within a 2K device |
| ram0_cs | output | 1 | RAM bank 0 select |
| ram1_cs | output | 1 | RAM bank 1 select |
| rom_cs | output | 1 | ROM select (reads only) |
| io_cs | output | 1 | Peripheral select |
| io_reg_sel | output | 1 | Peripheral register: 0 data, 1 status |
| mem_we | output | 1 | Write strobe for the selected writable device |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
The checker tests on every cycle that at most one select is high and that ROM or unmapped writes raise neither a select nor mem_we. It also tests that a RAM read is followed one cycle later by that bank's data, that an unmapped read is followed by $00, and that an idle cycle is followed by $00. Some properties depend on memory contents, so only the bench's scenarios can show them. These are: data written to a bank lands in that bank and not the other, the boundary addresses $07FF/$0800 and $0FFF/$1000/$1002, and that the little-endian reset vector reads back after a write to ROM was dropped.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_RAM0,
        SRC_RAM1,
        SRC_ROM,
        SRC_IO
    } src_e;

    typedef struct packed {
        logic ram0;
        logic ram1;
        logic rom;
        logic io;
    } hit_t;
endpackage

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
    import mmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 11,
    parameter logic [ADDR_W-1:0] RAM0_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0] RAM1_BASE = 16'h0800,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hF800,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output src_e              src,
    output logic              reg_sel
);
    localparam int N_MEM = 3;
    localparam logic [ADDR_W-1:0] MEM_BASES [N_MEM] = '{RAM0_BASE, RAM1_BASE, ROM_BASE};

    logic [N_MEM-1:0] mem_hit;

    for (genvar g = 0; g < N_MEM; g++) begin : g_mem
        assign mem_hit[g] = (addr[ADDR_W-1:MEM_AW] == MEM_BASES[g][ADDR_W-1:MEM_AW]);
    end

    always_comb begin
        hit.ram0 = mem_hit[0];
        hit.ram1 = mem_hit[1];
        hit.rom  = mem_hit[2];
        hit.io   = (addr[ADDR_W-1:1] == IO_BASE[ADDR_W-1:1]);
    end

    always_comb begin
        if (hit.ram0)      src = SRC_RAM0;
        else if (hit.ram1) src = SRC_RAM1;
        else if (hit.rom)  src = SRC_ROM;
        else if (hit.io)   src = SRC_IO;
        else               src = SRC_NONE;
    end

    assign reg_sel = addr[0];
endmodule

// File: rtl/mmd_read_mux.sv
module mmd_read_mux
    import mmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  src_e              rd_src,
    input  logic [DATA_W-1:0] ram0_rdata,
    input  logic [DATA_W-1:0] ram1_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] rdata
);
    src_e state_q, state_d;

    // next state: the source of this cycle's read, or none
    always_comb begin
        state_d = rd_req ? rd_src : SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_NONE;
        else        state_q <= state_d;
    end

    // output process: steer the device that was read last cycle
    always_comb begin
        unique case (state_q)
            SRC_RAM0: rdata = ram0_rdata;
            SRC_RAM1: rdata = ram1_rdata;
            SRC_ROM:  rdata = rom_rdata;
            SRC_IO:   rdata = io_rdata;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] ram0_rdata,
    input  logic [DATA_W-1:0] ram1_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              ram0_cs,
    output logic              ram1_cs,
    output logic              rom_cs,
    output logic              io_cs,
    output logic              io_reg_sel,
    output logic              mem_we,
    output logic [DATA_W-1:0] cpu_rdata
);
    hit_t hit;
    src_e src;
    logic rd, wr;

    mmd_region_decode #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dec (
        .addr    (cpu_addr),
        .hit     (hit),
        .src     (src),
        .reg_sel (io_reg_sel)
    );

    assign rd = cpu_req & ~cpu_we;
    assign wr = cpu_req &  cpu_we;

    assign ram0_cs  = cpu_req & hit.ram0;
    assign ram1_cs  = cpu_req & hit.ram1;
    assign rom_cs   = rd & hit.rom;
    assign io_cs    = cpu_req & hit.io;
    assign mem_we   = wr & (hit.ram0 | hit.ram1 | hit.io);
    assign mem_addr = cpu_addr[MEM_AW-1:0];

    mmd_read_mux #(.DATA_W(DATA_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd),
        .rd_src     (src),
        .ram0_rdata (ram0_rdata),
        .ram1_rdata (ram1_rdata),
        .rom_rdata  (rom_rdata),
        .io_rdata   (io_rdata),
        .rdata      (cpu_rdata)
    );
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [7:0]  ram0_rdata,
    input logic [7:0]  ram1_rdata,
    input logic        ram0_cs,
    input logic        ram1_cs,
    input logic        rom_cs,
    input logic        io_cs,
    input logic        mem_we,
    input logic [7:0]  cpu_rdata
);
    logic in_ram0, in_ram1, in_rom, mapped;
    assign in_ram0 = cpu_addr < 16'h0800;
    assign in_ram1 = (cpu_addr >= 16'h0800) && (cpu_addr < 16'h1000);
    assign in_rom  = cpu_addr >= 16'hF800;
    assign mapped  = (cpu_addr < 16'h1002) || in_rom;

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram0_cs, ram1_cs, rom_cs, io_cs}));

    a_r7_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && (in_rom || !mapped)) |-> (!rom_cs && !mem_we && !ram0_cs && !ram1_cs && !io_cs));

    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !mapped) |=> (cpu_rdata == 8'h00));

    a_r6_ram0_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && in_ram0) |=> (cpu_rdata == ram0_rdata));

    a_r6_ram1_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && in_ram1) |=> (cpu_rdata == ram1_rdata));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req) |=> (cpu_rdata == 8'h00));
endmodule

bind mem_map_decoder mmd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .ram0_rdata (ram0_rdata),
    .ram1_rdata (ram1_rdata),
    .ram0_cs    (ram0_cs),
    .ram1_cs    (ram1_cs),
    .rom_cs     (rom_cs),
    .io_cs      (io_cs),
    .mem_we     (mem_we),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/mem_map_decoder_bench.sv
module mem_map_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  ram0_q = 8'hEE, ram1_q = 8'hDD, rom_q = 8'hCC, io_q = 8'hBB;
    logic [10:0] mem_addr;
    logic        ram0_cs, ram1_cs, rom_cs, io_cs, io_reg_sel, mem_we;
    logic [7:0]  cpu_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    mem_map_decoder u_mem_map_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .ram0_rdata(ram0_q), .ram1_rdata(ram1_q), .rom_rdata(rom_q), .io_rdata(io_q),
        .mem_addr(mem_addr), .ram0_cs(ram0_cs), .ram1_cs(ram1_cs), .rom_cs(rom_cs),
        .io_cs(io_cs), .io_reg_sel(io_reg_sel), .mem_we(mem_we), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] rom_byte(input logic [10:0] off);
        case (off)
            11'h7FA: return 8'h00;
            11'h7FB: return 8'hF8;
            11'h7FC: return 8'h10;
            11'h7FD: return 8'hF8;
            11'h7FE: return 8'h20;
            11'h7FF: return 8'hF8;
            default: return 8'(off * 7 + 3) | 8'h01;
        endcase
    endfunction

    // device models (outside the block)
    logic [7:0] ram0 [2048];
    logic [7:0] ram1 [2048];
    logic [7:0] io_regs [2];
    always @(posedge clk) begin
        if (ram0_cs) begin
            if (mem_we) ram0[mem_addr] <= wdata; else ram0_q <= ram0[mem_addr];
        end
        if (ram1_cs) begin
            if (mem_we) ram1[mem_addr] <= wdata; else ram1_q <= ram1[mem_addr];
        end
        if (rom_cs) rom_q <= rom_byte(mem_addr);
        if (io_cs) begin
            if (mem_we) io_regs[io_reg_sel] <= wdata; else io_q <= io_regs[io_reg_sel];
        end
    end

    // reference model: flat view of the address map
    logic [7:0] ref_ram [4096];
    logic [7:0] ref_io [2];
    logic [7:0] exp_rd = 8'h00;
    string      exp_tag = "R10";
    logic [7:0] seen;

    function automatic logic [7:0] ref_read(input int a);
        if (a < 'h1000) return ref_ram[a];
        if (a == 'h1000 || a == 'h1001) return ref_io[a - 'h1000];
        if (a >= 'hF800) return rom_byte(11'(a - 'hF800));
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit req, input bit we, input int a, input logic [7:0] d);
        bit e0, e1, er, ei, ewe;
        string rt;
        @(negedge clk);
        #1;
        cpu_req = req; cpu_we = we; cpu_addr = 16'(a); wdata = d;
        #2;
        seen = cpu_rdata;
        chk(cpu_rdata === exp_rd, {"R6/", exp_tag}, cpu_rdata, exp_rd);
        e0 = req && a < 'h800;
        e1 = req && a >= 'h800 && a < 'h1000;
        ei = req && (a == 'h1000 || a == 'h1001);
        er = req && !we && a >= 'hF800;
        ewe = req && we && a < 'h1002;
        if (a < 'h800) rt = "R1";
        else if (a < 'h1000) rt = "R2";
        else if (a < 'h1002) rt = "R4";
        else if (a >= 'hF800) rt = "R3";
        else rt = "R5";
        if (req && we && (a >= 'h1002)) rt = "R7";
        chk({ram0_cs, ram1_cs, rom_cs, io_cs, mem_we} === {e0, e1, er, ei, ewe}, rt,
            {ram0_cs, ram1_cs, rom_cs, io_cs, mem_we}, {e0, e1, er, ei, ewe});
        chk($countones({ram0_cs, ram1_cs, rom_cs, io_cs}) <= 1, "R8",
            {ram0_cs, ram1_cs, rom_cs, io_cs}, 0);
        chk(mem_addr === 11'(a), "R9", mem_addr, a & 'h7FF);
        if (ei) chk(io_reg_sel === a[0], "R4", io_reg_sel, a[0]);
        if (req && !we) begin
            exp_rd = ref_read(a);
            exp_tag = (a < 'h1000) ? ((a < 'h800) ? "R1" : "R2") : rt;
            if (a >= 'hFFFA) exp_tag = "R11";
        end else begin
            exp_rd = 8'h00;
            exp_tag = "R10";
        end
        if (req && we) begin
            if (a < 'h1000) ref_ram[a] = d;
            else if (a == 'h1000 || a == 'h1001) ref_io[a - 'h1000] = d;
        end
    endtask

    task automatic rd_byte(input int a, output logic [7:0] v);
        step(1, 0, a, 8'h00);
        step(0, 0, 0, 8'h00);
        v = seen;
    endtask

    initial begin
        logic [7:0] lo, hi;
        for (int i = 0; i < 2048; i++) begin
            ram0[i] = 8'(i * 3 + 1);
            ram1[i] = 8'(i * 5 + 2);
            ref_ram[i] = 8'(i * 3 + 1);
            ref_ram[i + 2048] = 8'(i * 5 + 2);
        end
        io_regs[0] = 8'h11; io_regs[1] = 8'h02;
        ref_io[0] = 8'h11; ref_io[1] = 8'h02;

        // reset: output stays zero (R10)
        repeat (3) @(negedge clk);
        chk(cpu_rdata === 8'h00, "R10", cpu_rdata, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // RAM writes at bank edges (R1, R2, R7)
        step(1, 1, 'h0005, 8'hA5);
        step(1, 1, 'h07FF, 8'h5A);
        step(1, 1, 'h0800, 8'hC3);
        step(1, 1, 'h0FFF, 8'h3C);
        step(1, 1, 'h1000, 8'h77);
        // ignored writes (R7)
        step(1, 1, 'hFFFC, 8'h99);
        step(1, 1, 'h3000, 8'h99);
        step(1, 1, 'h1002, 8'h99);
        step(1, 1, 'hF7FF, 8'h99);
        // back-to-back reads across devices (R1-style tags per region, R6)
        step(1, 0, 'h0005, 0);
        step(1, 0, 'h07FF, 0);
        step(1, 0, 'h0800, 0);
        step(1, 0, 'h0FFF, 0);
        step(1, 0, 'h1000, 0);
        step(1, 0, 'h1001, 0);
        step(1, 0, 'h1002, 0);
        step(1, 0, 'hF800, 0);
        step(1, 0, 'h2000, 0);
        step(1, 0, 'hF7FF, 0);
        step(1, 0, 'h8000, 0);
        step(1, 0, 'h0005, 0);
        step(0, 0, 0, 0);

        // vectors, little-endian (R11)
        rd_byte('hFFFC, lo); rd_byte('hFFFD, hi);
        chk({hi, lo} === 16'hF810, "R11", {hi, lo}, 'hF810);
        rd_byte('hFFFA, lo); rd_byte('hFFFB, hi);
        chk({hi, lo} === 16'hF800, "R11", {hi, lo}, 'hF800);
        rd_byte('hFFFE, lo); rd_byte('hFFFF, hi);
        chk({hi, lo} === 16'hF820, "R11", {hi, lo}, 'hF820);

        // sweep the whole map, mixing reads, writes and idles
        for (int k = 0; k < 600; k++) begin
            int a;
            a = (k * 'h6D + (k >> 3) * 'h101) & 'hFFFF;
            if (k % 7 == 3) step(1, 1, a, 8'(k));
            else if (k % 11 == 5) step(0, 0, a, 0);
            else step(1, 0, a, 0);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule